// File: doc/BRIEF.md
# Coin Vendor with Change Return

A small clocked controller for a vending slot that takes two kinds of coin, a dime (10 cents) and a quarter (25 cents), against a 30-cent price. Each clock cycle presents at most one coin on a 2-bit code. The block keeps a running credit in one of four encoded states. It raises a dispense flag, and at most one change flag, in the same cycle as the coin that completes a purchase. The machine is of the Mealy kind: every output is a combinational function of the held state and the coin code in that cycle.

The block accepts four purchase sequences: dime-dime-dime, dime-quarter, quarter-dime and quarter-quarter. They return 0, 5, 5 and 20 cents of change respectively. Any other coin arrival, such as an unused code or a quarter while 20 cents is held, is ignored. Internally a control module owns the state register and decides whether a coin is accepted. A datapath module turns the held credit and the coin into a cent total, and from that total the dispense decision and the change flags.

Top module: `vend_change_top`

## Requirements
- R1: A synchronous active-high reset forces the idle state (no credit held). While reset is high, all three outputs are 0 whatever the coin code.
- R2: Coin code 2'b00 means no coin. It leaves the held credit unchanged and drives all outputs to 0.
- R3: From idle, three dimes (code 2'b01) raise dispense on the third dime, with both change flags 0.
- R4: From idle, a dime followed by a quarter (code 2'b10) raises dispense and the 5-cent change flag on the quarter.
- R5: From idle, a quarter followed by a dime raises dispense and the 5-cent change flag on the dime.
- R6: From idle, two quarters raise dispense and the 20-cent change flag on the second quarter.
- R7: A coin that does not complete a purchase drives all outputs to 0. Outputs appear only in the cycle of the completing coin, never one cycle later.
- R8: After any cycle with dispense high, the machine is back in idle at the next cycle.
- R9: Code 2'b11 is illegal. It leaves the held credit unchanged and drives all outputs to 0.
- R10: A quarter that arrives while 20 cents is held is ignored. The credit stays at 20 cents and all outputs are 0.
- R11: The two change flags are never high together, and neither is high without dispense.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coinCode | input | 2 | Coin this cycle: 00 none, 01 dime, 10 quarter, 11 illegal |
| dispense | output | 1 | Release the item this cycle |
| change20 | output | 1 | Return 20 cents this cycle |
| change5 | output | 1 | Return 5 cents this cycle |

## Verification
A wrong held credit stays invisible while no coin arrives. It shows at the ports on the next coin: dispense fires too early or too late, or the wrong change flag appears. So a fault surfaces at most one or two coins after it is made. The bench therefore drives every three-coin code pattern from idle, followed by an empty cycle. A reference credit counter in cents predicts each cycle's outputs, so a stale, skipped or mis-reset state is caught on the first coin that reads it. Back-to-back purchases with gaps, and a reset applied while credit is held, check that credit is cleared between sequences.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CENT_W    = 6;
  localparam int PRICE_C   = 30;
  localparam int DIME_C    = 10;
  localparam int QUARTER_C = 25;
  localparam int CHG_HI_C  = 20;
  localparam int CHG_LO_C  = 5;

  typedef enum logic [1:0] {
    COIN_NONE    = 2'b00,
    COIN_DIME    = 2'b01,
    COIN_QUARTER = 2'b10,
    COIN_BAD     = 2'b11
  } coin_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_TEN     = 2'b01,
    ST_TWENTY  = 2'b10,
    ST_QUARTER = 2'b11
  } vstate_e;

  typedef struct packed {
    logic              coinAccept;
    logic [CENT_W-1:0] heldCents;
  } ctrlStrobe_t;
endpackage

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  coin_e             coinIn,
  input  logic              vendNow,
  input  logic [CENT_W-1:0] totalCents,
  output ctrlStrobe_t       strobe
);
  vstate_e stateQ, stateD;
  logic    accept;

  // legality of the coin against the held credit
  always_comb begin
    accept = 1'b0;
    if (!rst) begin
      unique case (coinIn)
        COIN_DIME:    accept = 1'b1;
        COIN_QUARTER: accept = (stateQ != ST_TWENTY);
        default:      accept = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe.coinAccept = accept;
    unique case (stateQ)
      ST_TEN:     strobe.heldCents = CENT_W'(DIME_C);
      ST_TWENTY:  strobe.heldCents = CENT_W'(2 * DIME_C);
      ST_QUARTER: strobe.heldCents = CENT_W'(QUARTER_C);
      default:    strobe.heldCents = '0;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    if (accept) begin
      if (vendNow) begin
        stateD = ST_IDLE;
      end else begin
        if (totalCents == CENT_W'(DIME_C))            stateD = ST_TEN;
        else if (totalCents == CENT_W'(2 * DIME_C))   stateD = ST_TWENTY;
        else if (totalCents == CENT_W'(QUARTER_C))    stateD = ST_QUARTER;
        else                                          stateD = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> stateQ == ST_IDLE);
  p_hold_none_r2: assert property (@(posedge clk) disable iff (rst)
    coinIn == COIN_NONE |=> $stable(stateQ));
  p_idle_after_vend_r8: assert property (@(posedge clk) disable iff (rst)
    vendNow |=> stateQ == ST_IDLE);
  p_hold_bad_r9: assert property (@(posedge clk) disable iff (rst)
    coinIn == COIN_BAD |=> $stable(stateQ));
  p_twenty_quarter_r10: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_TWENTY && coinIn == COIN_QUARTER) |=> stateQ == ST_TWENTY);
endmodule

// File: rtl/vend_dp.sv
module vend_dp
  import vend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  coin_e             coinIn,
  input  ctrlStrobe_t       strobe,
  output logic              vendNow,
  output logic [CENT_W-1:0] totalCents,
  output logic              z1,
  output logic              z2,
  output logic              z3
);
  logic [CENT_W-1:0] coinCents;
  logic [CENT_W-1:0] changeCents;

  always_comb begin
    unique case (coinIn)
      COIN_DIME:    coinCents = CENT_W'(DIME_C);
      COIN_QUARTER: coinCents = CENT_W'(QUARTER_C);
      default:      coinCents = '0;
    endcase
  end

  assign totalCents  = strobe.heldCents + coinCents;
  assign vendNow     = strobe.coinAccept && (totalCents >= CENT_W'(PRICE_C));
  assign changeCents = totalCents - CENT_W'(PRICE_C);

  assign z1 = vendNow;
  assign z2 = vendNow && (changeCents == CENT_W'(CHG_HI_C));
  assign z3 = vendNow && (changeCents == CENT_W'(CHG_LO_C));

  p_none_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    coinIn == COIN_NONE |-> !z1 && !z2 && !z3);
  p_bad_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    coinIn == COIN_BAD |-> !z1 && !z2 && !z3);
  p_change_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (z2 || z3) |-> (z1 && !(z2 && z3)));
endmodule

// File: rtl/vend_change_top.sv
module vend_change_top
  import vend_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] coinCode,
  output logic       dispense,
  output logic       change20,
  output logic       change5
);
  coin_e             coinIn;
  ctrlStrobe_t       strobe;
  logic              vendNow;
  logic [CENT_W-1:0] totalCents;

  assign coinIn = coin_e'(coinCode);

  vend_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .coinIn     (coinIn),
    .vendNow    (vendNow),
    .totalCents (totalCents),
    .strobe     (strobe)
  );

  vend_dp dp_i (
    .clk        (clk),
    .rst        (rst),
    .coinIn     (coinIn),
    .strobe     (strobe),
    .vendNow    (vendNow),
    .totalCents (totalCents),
    .z1         (dispense),
    .z2         (change20),
    .z3         (change5)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> !dispense && !change20 && !change5);
endmodule

// File: tb/vend_change_top_tb_top.sv
module vend_change_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coinCode = 2'b00;
  logic       dispense, change20, change5;

  int checks = 0;
  int errors = 0;
  int heldModel = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vend_change_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .coinCode (coinCode),
    .dispense (dispense),
    .change20 (change20),
    .change5  (change5)
  );

  task automatic checkOut(string tag, logic e1, logic e2, logic e3);
    checks++;
    if ({dispense, change20, change5} !== {e1, e2, e3}) begin
      errors++;
      $display("FAIL %s: got %b%b%b expected %b%b%b (coin %b)", tag,
               dispense, change20, change5, e1, e2, e3, coinCode);
    end
    checks++;
    if ((change20 && change5) || ((change20 || change5) && !dispense)) begin
      errors++;
      $display("FAIL R11: got %b%b%b expected single change flag with dispense",
               dispense, change20, change5);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    coinCode = 2'b10;
    #1 checkOut("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    coinCode = 2'b00;
    heldModel = 0;
    #1 checkOut("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic applyCoin(logic [1:0] code);
    int    c;
    int    tot;
    bit    legal;
    bit    e1, e2, e3;
    string tag;
    @(negedge clk);
    coinCode = code;
    c = (code == 2'b01) ? 10 : (code == 2'b10) ? 25 : 0;
    legal = (code == 2'b01) || (code == 2'b10 && heldModel != 20);
    e1 = 0; e2 = 0; e3 = 0;
    if (!legal) begin
      tag = (code == 2'b00) ? "R2" : (code == 2'b11) ? "R9" : "R10";
    end else begin
      tot = heldModel + c;
      if (tot >= 30) begin
        e1 = 1;
        e2 = (tot - 30 == 20);
        e3 = (tot - 30 == 5);
        if (heldModel == 20)      tag = "R3";
        else if (heldModel == 10) tag = "R4";
        else if (code == 2'b01)   tag = "R5";
        else                      tag = "R6";
        heldModel = 0;
      end else begin
        tag = "R7";
        heldModel = tot;
      end
    end
    #1 checkOut(tag, e1, e2, e3);
  endtask

  initial begin
    doReset();
    // four legal purchases back to back with gaps
    applyCoin(2'b01); applyCoin(2'b01); applyCoin(2'b01);
    applyCoin(2'b00);
    applyCoin(2'b01); applyCoin(2'b10);
    applyCoin(2'b00); applyCoin(2'b00);
    applyCoin(2'b10); applyCoin(2'b01);
    applyCoin(2'b00);
    applyCoin(2'b10); applyCoin(2'b10);
    // R8: a purchase directly after a dispense starts from idle
    applyCoin(2'b01); applyCoin(2'b10);
    applyCoin(2'b10); applyCoin(2'b01);
    // R1: reset while credit is held clears it
    applyCoin(2'b10);
    doReset();
    applyCoin(2'b01); applyCoin(2'b01); applyCoin(2'b01);
    // exhaustive three-coin patterns from idle
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int d = 0; d < 4; d++) begin
          doReset();
          applyCoin(2'(a));
          applyCoin(2'(b));
          applyCoin(2'(d));
          applyCoin(2'b00);
        end
      end
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL R1: got hang expected run to complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule